// File: doc/BRIEF.md
# CPU Core Power State Controller

This block chooses and sequences the low-power state of a single processor core. Software programs two 2-bit fields: the target state the core should drop to and the clock transition mode. The core itself never says which state it wants. It only signals that it is waiting in wait-for-interrupt or in wait-for-event. A status input reports whether the shared cache behind the core is fully idle.

A low-power entry starts only when all of these hold at once:
- the core is in pure WFI;
- the clock mode is hardware-automatic;
- the shared cache is idle;
- the target field asks for INACTIVE or RETENTION;
- no wakeup is pending.

On entry the block first stops the core clock and waits a fixed settle window. It then reports the new state. For RETENTION it also raises a combined logic and memory retention request. A wakeup request brings the core back without any reset. The retention request and the reported state drop first, and the clock enable returns one cycle later. A wakeup that arrives while an entry is still settling cancels the entry by the same path. The configuration fields are frozen whenever the core is outside RUN.

Top module: `cpu_pwr_ctrl`

## Requirements
- R1: After reset, coreClkEn=1, coreRun=1, retReq=0 and pwrState=2'b00 (ON). Both configuration fields read 2'b00.
- R2: A write with cfgWrEn=1 updates a field at the clock edge. cfgWrSel=0 selects the target field and cfgWrSel=1 selects the clock mode field. cfgRdData shows the field chosen by cfgRdSel (same encoding) without delay.
- R3: A write presented while coreRun=0 leaves both fields unchanged.
- R4: While standbyWfe=1, no entry starts, even with standbyWfi=1. The outputs keep their RUN values.
- R5: Clock mode values 2'b00 (no sleep), 2'b01 and 2'b10 (software wakeup) never allow entry. Only 2'b11 (hardware automatic) does.
- R6: In hardware automatic mode, no entry starts if the target is 2'b00 (ON) or 2'b11, or if cacheIdle=0.
- R7: An entry starts at the edge where all entry conditions hold in RUN (see R4, R5, R6 and R12; target 2'b01 INACTIVE or 2'b10 RETENTION). Next cycle coreClkEn=0, coreRun=0 and pwrState stays ON. After SETTLE_CYC cycles, pwrState becomes 2'b01 with retReq=0 for INACTIVE, or 2'b10 with retReq=1 for RETENTION.
- R8: retReq is never 1 while coreClkEn is 1.
- R9: On a wakeup request in a low-power state, the next cycle shows retReq=0, pwrState=ON and coreClkEn=0. The cycle after that shows coreClkEn=1 and coreRun=1.
- R10: A wakeup request during the settle window aborts the entry through the same two-cycle return. No low-power state is reported.
- R11: A low-power state holds until wakeReq, whatever standbyWfi, cacheIdle or writes do. The block returns to RUN before any further entry.
- R12: wakeReq=1 in RUN prevents an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrSel | input | 1 | Write field select: 0 target, 1 clock mode |
| cfgWrData | input | 2 | Write value |
| cfgRdSel | input | 1 | Read field select: 0 target, 1 clock mode |
| cfgRdData | output | 2 | Selected field value |
| standbyWfi | input | 1 | Core waiting for interrupt |
| standbyWfe | input | 1 | Core waiting for event |
| cacheIdle | input | 1 | Shared cache fully idle |
| wakeReq | input | 1 | Wakeup request |
| coreClkEn | output | 1 | Core clock enable |
| retReq | output | 1 | Logic and memory retention request |
| pwrState | output | 2 | Reported state: 00 ON, 01 INACTIVE, 10 closed-switch retention |
| coreRun | output | 1 | Core is in RUN |

## Verification
The entry decision is tried with each qualifier withheld on its own: WFE together with WFI, each non-automatic clock mode, the ON and reserved targets, and a busy cache. Each of these patterns isolates one gating term. Entries to INACTIVE and to RETENTION tell the two reported codes and the retention request apart. Wakeups from a held state and during the settle window separate a normal return from an abort. A random phase then mixes writes, standby flags and wakeups. This exposes any ordering slip between the clock enable, the retention request and the reported state.

// File: rtl/cpu_pwr_pkg.sv
package cpu_pwr_pkg;
  localparam int FIELD_W = 2;

  localparam logic [FIELD_W-1:0] TGT_ON      = 2'b00;
  localparam logic [FIELD_W-1:0] TGT_INACT   = 2'b01;
  localparam logic [FIELD_W-1:0] TGT_RET     = 2'b10;
  localparam logic [FIELD_W-1:0] CLK_HW_AUTO = 2'b11;

  localparam logic [FIELD_W-1:0] PS_ON     = 2'b00;
  localparam logic [FIELD_W-1:0] PS_INACT  = 2'b01;
  localparam logic [FIELD_W-1:0] PS_CSWRET = 2'b10;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_GATE = 2'b01,
    ST_LOWP = 2'b10,
    ST_WAKE = 2'b11
  } ctl_state_e;

  typedef struct packed {
    logic latchTgt;
    logic cfgLock;
  } dp_strobe_t;
endpackage

// File: rtl/cpu_pwr_dp.sv
module cpu_pwr_dp
  import cpu_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic               cfgWrSel,
  input  logic [FIELD_W-1:0] cfgWrData,
  input  logic               cfgRdSel,
  output logic [FIELD_W-1:0] cfgRdData,
  input  logic               standbyWfi,
  input  logic               standbyWfe,
  input  logic               cacheIdle,
  input  logic               wakeReq,
  input  dp_strobe_t         strobe,
  output logic               entryOk,
  output logic               lpIsRet
);
  logic [FIELD_W-1:0] tgtReg;
  logic [FIELD_W-1:0] clkModeReg;
  logic               tgtLowPower;
  logic               wrAllowed;

  assign wrAllowed = cfgWrEn && !strobe.cfgLock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgtReg     <= TGT_ON;
      clkModeReg <= '0;
    end else if (wrAllowed) begin
      if (cfgWrSel) clkModeReg <= cfgWrData;
      else          tgtReg     <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lpIsRet <= 1'b0;
    else if (strobe.latchTgt) lpIsRet <= (tgtReg == TGT_RET);
  end

  assign cfgRdData   = cfgRdSel ? clkModeReg : tgtReg;
  assign tgtLowPower = (tgtReg == TGT_INACT) || (tgtReg == TGT_RET);

  always_comb begin
    entryOk = standbyWfi && !standbyWfe && cacheIdle && !wakeReq
              && (clkModeReg == CLK_HW_AUTO) && tgtLowPower;
  end

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cfgLock |=> ($stable(tgtReg) && $stable(clkModeReg)));

  p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.latchTgt |=> $stable(lpIsRet));
endmodule

// File: rtl/cpu_pwr_ctl.sv
module cpu_pwr_ctl
  import cpu_pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               entryOk,
  input  logic               lpIsRet,
  input  logic               wakeReq,
  output dp_strobe_t         strobe,
  output logic               coreClkEn,
  output logic               retReq,
  output logic [FIELD_W-1:0] pwrState,
  output logic               coreRun
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  ctl_state_e       state, stateNxt;
  logic [CNT_W-1:0] settleCnt, settleCntNxt;

  always_comb begin
    stateNxt     = state;
    settleCntNxt = settleCnt;
    unique case (state)
      ST_RUN: begin
        settleCntNxt = '0;
        if (entryOk) stateNxt = ST_GATE;
      end
      ST_GATE: begin
        if (wakeReq)                    stateNxt = ST_WAKE;
        else if (settleCnt == CNT_LAST) stateNxt = ST_LOWP;
        else                            settleCntNxt = settleCnt + 1'b1;
      end
      ST_LOWP: if (wakeReq) stateNxt = ST_WAKE;
      ST_WAKE: stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      settleCnt <= '0;
    end else begin
      state     <= stateNxt;
      settleCnt <= settleCntNxt;
    end
  end

  always_comb begin
    strobe.latchTgt = (state == ST_RUN) && entryOk;
    strobe.cfgLock  = (state != ST_RUN);
  end

  assign coreClkEn = (state == ST_RUN);
  assign coreRun   = (state == ST_RUN);
  assign retReq    = (state == ST_LOWP) && lpIsRet;

  always_comb begin
    if (state == ST_LOWP) pwrState = lpIsRet ? PS_CSWRET : PS_INACT;
    else                  pwrState = PS_ON;
  end

  p_entry_gates_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coreRun && entryOk) |=> (!coreClkEn && pwrState == PS_ON));

  p_clk_off_before_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retReq |-> !coreClkEn);

  p_wake_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrState != PS_ON && wakeReq) |=> (!retReq && pwrState == PS_ON && !coreClkEn));

  p_clk_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(retReq) |=> coreClkEn);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GATE && wakeReq) |=> (state == ST_WAKE && pwrState == PS_ON));

  p_hold_lowp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrState != PS_ON && !wakeReq) |=> $stable(pwrState));
endmodule

// File: rtl/cpu_pwr_ctrl.sv
module cpu_pwr_ctrl
  import cpu_pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWrEn,
  input  logic               cfgWrSel,
  input  logic [FIELD_W-1:0] cfgWrData,
  input  logic               cfgRdSel,
  output logic [FIELD_W-1:0] cfgRdData,
  input  logic               standbyWfi,
  input  logic               standbyWfe,
  input  logic               cacheIdle,
  input  logic               wakeReq,
  output logic               coreClkEn,
  output logic               retReq,
  output logic [FIELD_W-1:0] pwrState,
  output logic               coreRun
);
  dp_strobe_t strobe;
  logic       entryOk;
  logic       lpIsRet;

  cpu_pwr_dp u_dp (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData),
    .cfgRdSel(cfgRdSel), .cfgRdData(cfgRdData),
    .standbyWfi(standbyWfi), .standbyWfe(standbyWfe),
    .cacheIdle(cacheIdle), .wakeReq(wakeReq),
    .strobe(strobe), .entryOk(entryOk), .lpIsRet(lpIsRet)
  );

  cpu_pwr_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .entryOk(entryOk), .lpIsRet(lpIsRet), .wakeReq(wakeReq),
    .strobe(strobe), .coreClkEn(coreClkEn), .retReq(retReq),
    .pwrState(pwrState), .coreRun(coreRun)
  );
endmodule

// File: tb/cpu_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_pwr_ctrl_bench;
  localparam int SETTLE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0, cfgWrSel = 1'b0, cfgRdSel = 1'b0;
  logic [1:0] cfgWrData = 2'b00;
  logic       standbyWfi = 1'b0, standbyWfe = 1'b0, cacheIdle = 1'b0, wakeReq = 1'b0;
  logic [1:0] cfgRdData, pwrState;
  logic       coreClkEn, retReq, coreRun;

  int    vecCnt = 0;
  int    failCnt = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  cpu_pwr_ctrl #(.SETTLE_CYC(SETTLE)) u_cpu_pwr_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData),
    .cfgRdSel(cfgRdSel), .cfgRdData(cfgRdData),
    .standbyWfi(standbyWfi), .standbyWfe(standbyWfe),
    .cacheIdle(cacheIdle), .wakeReq(wakeReq),
    .coreClkEn(coreClkEn), .retReq(retReq),
    .pwrState(pwrState), .coreRun(coreRun)
  );

  // reference model: phase 0 run, 1 settling, 2 low power, 3 returning
  int mPhase, mCnt, mTgt, mMode;
  bit mRet;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPhase = 0; mCnt = 0; mTgt = 0; mMode = 0; mRet = 0;
    end else begin
      int  oldPhase;
      bit  go;
      oldPhase = mPhase;
      go = standbyWfi && !standbyWfe && cacheIdle && !wakeReq && mMode == 3
           && (mTgt == 1 || mTgt == 2);
      case (mPhase)
        0: if (go) begin mPhase = 1; mCnt = 1; mRet = (mTgt == 2); end
        1: if (wakeReq) mPhase = 3;
           else if (mCnt >= SETTLE) mPhase = 2;
           else mCnt++;
        2: if (wakeReq) mPhase = 3;
        default: mPhase = 0;
      endcase
      if (cfgWrEn && oldPhase == 0) begin
        if (cfgWrSel) mMode = int'(cfgWrData);
        else          mTgt  = int'(cfgWrData);
      end
    end
  end

  task automatic cmp(string tag, int act, int exp, string what);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int expPs;
      expPs = (mPhase == 2) ? (mRet ? 2 : 1) : 0;
      cmp(curReq, int'(coreClkEn), int'(mPhase == 0), "coreClkEn");
      cmp(curReq, int'(coreRun),   int'(mPhase == 0), "coreRun");
      cmp(curReq, int'(retReq),    int'(mPhase == 2 && mRet), "retReq");
      cmp(curReq, int'(pwrState),  expPs, "pwrState");
      cmp(curReq, int'(cfgRdData), cfgRdSel ? mMode : mTgt, "cfgRdData");
      if (retReq && coreClkEn) cmp("R8", 1, 0, "retReq with clock on");
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(bit sel, logic [1:0] val);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = val;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    curReq = "R1";
    cmp("R1", int'(pwrState), 0, "reset pwrState");
    cmp("R1", int'(coreClkEn), 1, "reset coreClkEn");

    curReq = "R2";
    wr(1'b0, 2'b01);
    cmp("R2", int'(cfgRdData), 1, "target readback");
    cfgRdSel = 1'b1;
    wr(1'b1, 2'b00);
    cmp("R2", int'(cfgRdData), 0, "mode readback");

    curReq = "R5";
    standbyWfi = 1'b1; cacheIdle = 1'b1;
    tick(4);
    wr(1'b1, 2'b01); tick(3);
    wr(1'b1, 2'b10); tick(3);
    cmp("R5", int'(coreRun), 1, "no entry without automatic mode");
    standbyWfi = 1'b0;
    wr(1'b1, 2'b11);

    curReq = "R4";
    standbyWfi = 1'b1; standbyWfe = 1'b1;
    tick(4);
    cmp("R4", int'(coreClkEn), 1, "wfe blocks entry");
    standbyWfi = 1'b0; standbyWfe = 1'b0;

    curReq = "R6";
    cfgRdSel = 1'b0;
    wr(1'b0, 2'b00); standbyWfi = 1'b1; tick(3);
    standbyWfi = 1'b0; wr(1'b0, 2'b11); standbyWfi = 1'b1; tick(3);
    standbyWfi = 1'b0; wr(1'b0, 2'b01); cacheIdle = 1'b0; standbyWfi = 1'b1; tick(3);
    cmp("R6", int'(coreRun), 1, "busy cache blocks entry");

    curReq = "R12";
    wakeReq = 1'b1; cacheIdle = 1'b1;
    tick(3);
    cmp("R12", int'(coreRun), 1, "wake blocks entry");

    curReq = "R7";
    wakeReq = 1'b0;
    tick(1);
    cmp("R7", int'(coreClkEn), 0, "clock gated first");
    cmp("R7", int'(pwrState), 0, "still ON while settling");
    tick(SETTLE);
    cmp("R7", int'(pwrState), 1, "inactive reported");

    curReq = "R3";
    wr(1'b0, 2'b10);
    cmp("R3", int'(cfgRdData), 1, "locked target unchanged");

    curReq = "R11";
    standbyWfi = 1'b0; cacheIdle = 1'b0;
    tick(3);
    cmp("R11", int'(pwrState), 1, "state held");

    curReq = "R9";
    wakeReq = 1'b1; tick(1); wakeReq = 1'b0;
    cmp("R9", int'(coreClkEn), 0, "clock still off during return");
    tick(1);
    cmp("R9", int'(coreRun), 1, "back in run");
    tick(2);

    curReq = "R7";
    wr(1'b0, 2'b10);
    standbyWfi = 1'b1; cacheIdle = 1'b1;
    tick(SETTLE + 2);
    cmp("R7", int'(pwrState), 2, "retention reported");
    cmp("R8", int'(retReq), 1, "retention requested");
    curReq = "R9";
    standbyWfi = 1'b0;
    wakeReq = 1'b1; tick(1); wakeReq = 1'b0;
    cmp("R9", int'(retReq), 0, "retention released");
    tick(1);
    cmp("R9", int'(coreClkEn), 1, "clock back after release");

    curReq = "R10";
    standbyWfi = 1'b1;
    tick(1);
    wakeReq = 1'b1; tick(1); wakeReq = 1'b0; standbyWfi = 1'b0;
    cmp("R10", int'(pwrState), 0, "aborted entry stays ON");
    tick(1);
    cmp("R10", int'(coreRun), 1, "abort returns to run");
    tick(2);

    curReq = "R11";
    for (int i = 0; i < 400; i++) begin
      cfgWrEn    = ($urandom_range(0, 7) == 0);
      cfgWrSel   = 1'($urandom_range(0, 1));
      cfgWrData  = 2'($urandom_range(0, 3));
      cfgRdSel   = 1'($urandom_range(0, 1));
      standbyWfi = ($urandom_range(0, 3) != 0);
      standbyWfe = ($urandom_range(0, 7) == 0);
      cacheIdle  = ($urandom_range(0, 3) != 0);
      wakeReq    = ($urandom_range(0, 5) == 0);
      tick(1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule